// File: doc/BRIEF.md
# ISA Bus Cycle Controller

This block is the master side of an ISA-style peripheral bus. It accepts one request at a time from inside the chip. A request carries a cycle kind (plain I/O, plain memory, DMA, card I/O or card memory), a direction, a width, an address and write data. The block turns the request into the bus sequence: an address phase with a latch pulse, a command phase with one read or write strobe, and a recovery gap. Each phase has a minimum length set by a parameter. The command phase is stretched for as long as the target holds ready low. When the last recovery cycle ends, the block pulses a completion flag and holds any read data on its response port.

The address latch pulses on every pass of every cycle kind, so no device can act on a stale latched address. The DMA address-enable output stays high for the whole sequence of DMA cycles and of card I/O cycles. Plain bus devices therefore ignore the shared strobes during those cycles. The two 16-bit select inputs are sampled in the last address cycle: the I/O one for I/O kinds, the memory one for the other kinds. A 16-bit request to an 8-bit target becomes two byte passes, low byte first. A shared transceiver enable and two per-lane direction controls steer the external data buffer.

Top module: `isa_cycle_ctrl`

## Requirements
- R1: While reset is asserted, all strobes, `bale`, `aen`, `xcvr_oe` and `req_done` are low and `req_ready` is high. Reset is asynchronous and takes effect mid-cycle.
- R2: Each pass begins with exactly ADDR_CYC cycles of `bale` high, for every cycle kind. No strobe is active during those cycles, and a strobe never starts without `bale` in the cycle before.
- R3: `aen` is high in every busy cycle of kinds 2 (DMA) and 3 (card I/O), and low throughout kinds 0 (I/O), 1 (memory) and 4 (card memory). It falls in the cycle that `req_done` is high.
- R4: Kinds 0 and 3 use `io_rd` / `io_wr`, and all other kinds use `mem_rd` / `mem_wr`. `req_write` = 1 selects the write strobe. At most one strobe is ever high.
- R5: The strobe lasts at least CMD_CYC cycles. If `bus_rdy` is low at the edge where the minimum expires, the strobe holds until an edge where `bus_rdy` is high.
- R6: For kinds 0 and 3, `io_cs16` high in the last address cycle makes a `req_wide` access one 16-bit transfer on both lanes. Low makes it 8-bit. `mem_cs16` has no effect on these kinds.
- R7: For kinds 1, 2 and 4, `mem_cs16` decides the width in the same way, and `io_cs16` has no effect.
- R8: A `req_wide` access to an 8-bit target runs two full passes. The first presents the address with bit 0 as given and the low data byte. The second presents bit 0 forced to 1 and the high data byte. Both bytes travel on lane bits 7:0, and the read result is assembled as {second, first}.
- R9: `xcvr_oe` is high exactly while a strobe is high. `xcvr_dir_lo` is high in every busy cycle of a write. `xcvr_dir_hi` is high only in writes that are 16-bit transfers, from the command phase through recovery.
- R10: `req_done` is a single-cycle pulse, one per request, in the first idle cycle. `rsp_rdata` then holds the read result. A narrow (`req_wide` = 0) read returns its byte in bits 7:0 with bits 15:8 zero.
- R11: Each pass ends with RECOV_CYC recovery cycles. A request is busy for exactly passes × (ADDR_CYC + strobe length + RECOV_CYC) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_kind | input | 3 | 0 I/O, 1 memory, 2 DMA, 3 card I/O, 4 card memory |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 16-bit request |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Read result |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bale | output | 1 | Address latch enable |
| aen | output | 1 | DMA address enable |
| io_rd | output | 1 | I/O read strobe (active high) |
| io_wr | output | 1 | I/O write strobe (active high) |
| mem_rd | output | 1 | Memory read strobe (active high) |
| mem_wr | output | 1 | Memory write strobe (active high) |
| bus_rdy | input | 1 | Target ready, low inserts wait states |
| io_cs16 | input | 1 | I/O target is 16 bits wide |
| mem_cs16 | input | 1 | Memory target is 16 bits wide |
| xcvr_oe | output | 1 | Data transceiver output enable |
| xcvr_dir_hi | output | 1 | Upper lane direction, 1 = outbound |
| xcvr_dir_lo | output | 1 | Lower lane direction, 1 = outbound |

## Verification
Two events can land on the same clock edge: the programmed minimum command count runs out, and the target's ready input decides whether the strobe ends or holds. The bench lets its device model hold ready low until a chosen number of cycles past the minimum, which can be zero, so that both fall together. It judges the result by the exact strobe length and the total busy count. In split accesses a second pair coincides: the first pass's recovery ends and the second pass's latch pulse begins. The bench checks that pairing through the captured second address, which has bit 0 set, and through the assembled read word.

// File: rtl/isa_cyc_pkg.sv
package isa_cyc_pkg;

   typedef enum logic [2:0] {
      KIND_IO       = 3'd0,
      KIND_MEM      = 3'd1,
      KIND_DMA      = 3'd2,
      KIND_CARD_IO  = 3'd3,
      KIND_CARD_MEM = 3'd4
   } cyc_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ADDR  = 2'd1,
      PH_CMD   = 2'd2,
      PH_RECOV = 2'd3
   } phase_e;

   // kinds that drive the I/O strobe pair
   function automatic logic kind_is_io(input cyc_kind_e k);
      return (k == KIND_IO) || (k == KIND_CARD_IO);
   endfunction

   // kinds during which plain bus devices must stay off the bus
   function automatic logic kind_hides_bus(input cyc_kind_e k);
      return (k == KIND_DMA) || (k == KIND_CARD_IO);
   endfunction

endpackage

// File: rtl/isa_phase_fsm.sv
module isa_phase_fsm
   import isa_cyc_pkg::*;
#(
   parameter int ADDR_CYC  = 1,
   parameter int CMD_CYC   = 4,
   parameter int RECOV_CYC = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   wide_req,
   input  logic   width16_in,
   input  logic   bus_rdy,
   output phase_e phase,
   output logic   pass,
   output logic   is16,
   output logic   cmd_end,
   output logic   done
);

   localparam int MAX_AC = (ADDR_CYC > CMD_CYC) ? ADDR_CYC : CMD_CYC;
   localparam int MAXC   = (MAX_AC > RECOV_CYC) ? MAX_AC : RECOV_CYC;
   localparam int CW     = $clog2(MAXC + 1);
   localparam logic [CW-1:0] LD_ADDR  = CW'(ADDR_CYC - 1);
   localparam logic [CW-1:0] LD_CMD   = CW'(CMD_CYC - 1);
   localparam logic [CW-1:0] LD_RECOV = CW'(RECOV_CYC - 1);

   logic [CW-1:0] cnt;
   logic          cnt_zero;

   assign cnt_zero = (cnt == '0);
   assign cmd_end  = (phase == PH_CMD) && cnt_zero && bus_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         pass  <= 1'b0;
         is16  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_ADDR;
                  cnt   <= LD_ADDR;
                  pass  <= 1'b0;
                  is16  <= 1'b0;
               end
            end
            PH_ADDR: begin
               if (cnt_zero) begin
                  phase <= PH_CMD;
                  cnt   <= LD_CMD;
                  if (!pass) is16 <= width16_in;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_CMD: begin
               if (!cnt_zero) begin
                  cnt <= cnt - 1'b1;
               end else if (bus_rdy) begin
                  phase <= PH_RECOV;
                  cnt   <= LD_RECOV;
               end
            end
            PH_RECOV: begin
               if (!cnt_zero) begin
                  cnt <= cnt - 1'b1;
               end else if (wide_req && !is16 && !pass) begin
                  phase <= PH_ADDR;
                  cnt   <= LD_ADDR;
                  pass  <= 1'b1;
               end else begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen
   import isa_cyc_pkg::*;
(
   input  phase_e    phase,
   input  cyc_kind_e kind,
   input  logic      write,
   input  logic      lane16,
   output logic      bale,
   output logic      aen,
   output logic      io_rd,
   output logic      io_wr,
   output logic      mem_rd,
   output logic      mem_wr,
   output logic      xcvr_oe,
   output logic      xcvr_dir_hi,
   output logic      xcvr_dir_lo
);

   logic active;
   logic in_cmd;
   logic use_io;

   assign active = (phase != PH_IDLE);
   assign in_cmd = (phase == PH_CMD);
   assign use_io = kind_is_io(kind);

   assign bale   = (phase == PH_ADDR);
   assign aen    = active && kind_hides_bus(kind);

   assign io_rd  = in_cmd &&  use_io && !write;
   assign io_wr  = in_cmd &&  use_io &&  write;
   assign mem_rd = in_cmd && !use_io && !write;
   assign mem_wr = in_cmd && !use_io &&  write;

   assign xcvr_oe     = in_cmd;
   assign xcvr_dir_lo = active && write;
   assign xcvr_dir_hi = active && write && lane16;

endmodule

// File: rtl/isa_data_lane.sv
module isa_data_lane (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        cmd_end,
   input  logic        pass,
   input  logic        lane16,
   input  logic [15:0] wdata,
   input  logic [15:0] bus_rdata,
   output logic [15:0] bus_wdata,
   output logic [15:0] rdata
);

   localparam int LANES = 2;
   localparam int BW    = 8;

   // 8-bit targets see each byte on the low lane, upper lane kept at the high byte
   assign bus_wdata = lane16 ? wdata
                             : {wdata[15:8], (pass ? wdata[15:8] : wdata[7:0])};

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [BW-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (start) begin
            byte_q <= '0;
         end else if (cmd_end) begin
            if (lane16)
               byte_q <= bus_rdata[BW*b +: BW];
            else if (pass == 1'(b))
               byte_q <= bus_rdata[BW-1:0];
         end
      end
      assign rdata[BW*b +: BW] = byte_q;
   end

endmodule

// File: rtl/isa_cycle_ctrl.sv
module isa_cycle_ctrl
   import isa_cyc_pkg::*;
#(
   parameter int AW        = 24,
   parameter int ADDR_CYC  = 1,
   parameter int CMD_CYC   = 4,
   parameter int RECOV_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [2:0]    req_kind,
   input  logic          req_write,
   input  logic          req_wide,
   input  logic [AW-1:0] req_addr,
   input  logic [15:0]   req_wdata,
   output logic          req_done,
   output logic [15:0]   rsp_rdata,
   output logic [AW-1:0] bus_addr,
   output logic [15:0]   bus_wdata,
   input  logic [15:0]   bus_rdata,
   output logic          bale,
   output logic          aen,
   output logic          io_rd,
   output logic          io_wr,
   output logic          mem_rd,
   output logic          mem_wr,
   input  logic          bus_rdy,
   input  logic          io_cs16,
   input  logic          mem_cs16,
   output logic          xcvr_oe,
   output logic          xcvr_dir_hi,
   output logic          xcvr_dir_lo
);

   if (ADDR_CYC < 1 || CMD_CYC < 1 || RECOV_CYC < 1) begin : g_bad_phase
      $error("isa_cycle_ctrl: every phase needs at least one cycle");
   end
   if (AW < 2) begin : g_bad_aw
      $error("isa_cycle_ctrl: AW must be at least 2");
   end

   phase_e        phase;
   logic          start;
   logic          pass;
   logic          is16;
   logic          cmd_end;
   logic          lane16;
   logic          width16_sel;
   logic          cmd_any;
   cyc_kind_e     kind_q;
   logic          wr_q;
   logic          wide_q;
   logic [AW-1:0] addr_q;
   logic [15:0]   wdata_q;

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= KIND_IO;
         wr_q    <= 1'b0;
         wide_q  <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start) begin
         kind_q  <= cyc_kind_e'(req_kind);
         wr_q    <= req_write;
         wide_q  <= req_wide;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   assign width16_sel = kind_is_io(kind_q) ? io_cs16 : mem_cs16;
   assign lane16      = wide_q && is16;
   assign bus_addr    = {addr_q[AW-1:1], addr_q[0] | pass};

   isa_phase_fsm #(
      .ADDR_CYC  (ADDR_CYC),
      .CMD_CYC   (CMD_CYC),
      .RECOV_CYC (RECOV_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .wide_req   (wide_q),
      .width16_in (width16_sel),
      .bus_rdy    (bus_rdy),
      .phase      (phase),
      .pass       (pass),
      .is16       (is16),
      .cmd_end    (cmd_end),
      .done       (req_done)
   );

   isa_strobe_gen u_strobe (
      .phase       (phase),
      .kind        (kind_q),
      .write       (wr_q),
      .lane16      (lane16),
      .bale        (bale),
      .aen         (aen),
      .io_rd       (io_rd),
      .io_wr       (io_wr),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .xcvr_oe     (xcvr_oe),
      .xcvr_dir_hi (xcvr_dir_hi),
      .xcvr_dir_lo (xcvr_dir_lo)
   );

   isa_data_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmd_end   (cmd_end),
      .pass      (pass),
      .lane16    (lane16),
      .wdata     (wdata_q),
      .bus_rdata (bus_rdata),
      .bus_wdata (bus_wdata),
      .rdata     (rsp_rdata)
   );

   assign cmd_any = io_rd | io_wr | mem_rd | mem_wr;

   AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_any && !bus_rdy) |=> cmd_any); // R5

   AST_LATCH_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_any) |-> $past(bale)); // R2

   AST_AEN_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(aen) |-> req_done); // R3

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done); // R10

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({io_rd, io_wr, mem_rd, mem_wr})); // R4

   AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      xcvr_dir_hi |-> xcvr_dir_lo); // R9

   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !req_done) |=> !req_done || $past(phase == PH_RECOV)); // R10

endmodule

// File: tb/isa_cycle_ctrl_bench.sv
module isa_cycle_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 24;
   localparam int A_C = 2;
   localparam int C_C = 3;
   localparam int R_C = 2;

   typedef struct packed {
      logic [2:0]  kind;
      logic        wr;
      logic        wide;
      logic        cs_io;
      logic        cs_mem;
      logic [3:0]  waits;
      logic [23:0] addr;
      logic [15:0] wdata;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 24'h000310, 16'h0000},
      '{3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 24'h000320, 16'h0000},
      '{3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 24'h0A0000, 16'hBEEF},
      '{3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 24'h0A0010, 16'h1234},
      '{3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 24'h000040, 16'h0000},
      '{3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 4'd1, 24'h0003E0, 16'hA55A},
      '{3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 24'h0D0002, 16'h0000},
      '{3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 24'h000061, 16'h77C3}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_kind = '0;
   logic          req_write = 1'b0;
   logic          req_wide = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   req_wdata = '0;
   logic          req_done;
   logic [15:0]   rsp_rdata;
   logic [AW-1:0] bus_addr;
   logic [15:0]   bus_wdata;
   logic [15:0]   bus_rdata;
   logic          bale, aen, io_rd, io_wr, mem_rd, mem_wr;
   logic          bus_rdy;
   logic          io_cs16 = 1'b0;
   logic          mem_cs16 = 1'b0;
   logic          xcvr_oe, xcvr_dir_hi, xcvr_dir_lo;

   always #(CLK_PERIOD/2) clk = ~clk;

   isa_cycle_ctrl #(
      .AW(AW), .ADDR_CYC(A_C), .CMD_CYC(C_C), .RECOV_CYC(R_C)
   ) u_isa_cycle_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_write(req_write), .req_wide(req_wide),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
      .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bale(bale), .aen(aen), .io_rd(io_rd),
      .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_rdy(bus_rdy),
      .io_cs16(io_cs16), .mem_cs16(mem_cs16), .xcvr_oe(xcvr_oe),
      .xcvr_dir_hi(xcvr_dir_hi), .xcvr_dir_lo(xcvr_dir_lo)
   );

   // device model: read data derived from the address
   function automatic logic [15:0] dev_rd(input logic [23:0] a);
      return {8'hC0 ^ a[7:0], 8'h30 ^ a[7:0]};
   endfunction

   int n_chk = 0;
   int n_bad = 0;
   int cur_waits = 0;
   int cur_kind = 0;
   int cur_wr = 0;
   int scnt = 0;
   int mon = 0;
   int n_busy, n_bale, n_aen, n_str, n_wrong, n_hi, n_lo, n_oebad, n_done, widx;
   logic [15:0]   wcap [2];
   logic [AW-1:0] acap [2];
   logic          prev_str = 1'b0;
   int            cyc_total = 0;

   assign bus_rdata = dev_rd(bus_addr);
   assign bus_rdy   = (scnt >= C_C + cur_waits);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      logic any_s, right_s, io_k;
      any_s   = io_rd | io_wr | mem_rd | mem_wr;
      io_k    = (cur_kind == 0) || (cur_kind == 3);
      right_s = io_k ? ((cur_wr != 0) ? io_wr : io_rd) : ((cur_wr != 0) ? mem_wr : mem_rd);
      if (mon != 0) begin
         if (!req_ready) n_busy++;
         if (bale) n_bale++;
         if (aen) n_aen++;
         if (right_s) n_str++;
         if (any_s && !right_s) n_wrong++;
         if (xcvr_dir_hi) n_hi++;
         if (xcvr_dir_lo) n_lo++;
         if (xcvr_oe != any_s) n_oebad++;
         if (req_done) n_done++;
         if (any_s && !prev_str) begin
            if (widx < 2) begin
               wcap[widx] = bus_wdata;
               acap[widx] = bus_addr;
            end
            widx++;
         end
      end
      prev_str = any_s;
      scnt = any_s ? scnt + 1 : 0;
   end

   task automatic summary_and_end();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL R10 watchdog act=%0d exp=<100000", cyc_total);
         summary_and_end();
      end
   end

   task automatic check_idle(input string tag);
      chk({tag, " strobes"}, {28'd0, io_rd, io_wr, mem_rd, mem_wr}, 32'd0);
      chk({tag, " bale/aen"}, {30'd0, bale, aen}, 32'd0);
      chk({tag, " oe/done"}, {30'd0, xcvr_oe, req_done}, 32'd0);
      chk({tag, " ready"}, {31'd0, req_ready}, 32'd1);
   endtask

   task automatic run(input vec_t v);
      logic io_k, cs, lane16;
      int   p, cyc, str_len;
      logic [15:0] exp_rd;
      io_k    = (v.kind == 3'd0) || (v.kind == 3'd3);
      cs      = io_k ? v.cs_io : v.cs_mem;
      lane16  = v.wide && cs;
      p       = (v.wide && !cs) ? 2 : 1;
      str_len = C_C + int'(v.waits);
      cyc     = A_C + str_len + R_C;

      @(posedge clk); #1;
      cur_waits = int'(v.waits);
      cur_kind  = int'(v.kind);
      cur_wr    = int'(v.wr);
      io_cs16   = v.cs_io;
      mem_cs16  = v.cs_mem;
      n_busy = 0; n_bale = 0; n_aen = 0; n_str = 0; n_wrong = 0;
      n_hi = 0; n_lo = 0; n_oebad = 0; n_done = 0; widx = 0;
      mon = 1;
      req_kind = v.kind; req_write = v.wr; req_wide = v.wide;
      req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (n_done > 0) break;
      end
      @(negedge clk);
      @(negedge clk);
      mon = 0;

      chk("R10 one done pulse", 32'(n_done), 32'd1);
      chk("R11 busy cycles", 32'(n_busy), 32'(p * cyc));
      chk("R2 latch cycles", 32'(n_bale), 32'(p * A_C));
      chk("R5 strobe cycles", 32'(n_str), 32'(p * str_len));
      chk("R4 wrong strobe", 32'(n_wrong), 32'd0);
      chk("R3 aen cycles", 32'(n_aen),
          ((v.kind == 3'd2) || (v.kind == 3'd3)) ? 32'(p * cyc) : 32'd0);
      chk("R9 dir_lo cycles", 32'(n_lo), v.wr ? 32'(p * cyc) : 32'd0);
      chk("R9 dir_hi cycles", 32'(n_hi), (v.wr && lane16) ? 32'(str_len + R_C) : 32'd0);
      chk("R9 oe tracks strobe", 32'(n_oebad), 32'd0);
      chk(io_k ? "R6 pass count" : "R7 pass count", 32'(widx), 32'(p));
      chk("R8 first address", 32'(acap[0]), 32'(v.addr));
      if (p == 2) begin
         chk("R8 second address", 32'(acap[1]), 32'(v.addr | 24'h1));
      end
      if (v.wr) begin
         if (lane16) begin
            chk("R6 word on bus", 32'(wcap[0]), 32'(v.wdata));
         end else begin
            chk("R8 low byte first", 32'(wcap[0][7:0]), 32'(v.wdata[7:0]));
            if (p == 2)
               chk("R8 high byte second", 32'(wcap[1][7:0]), 32'(v.wdata[15:8]));
         end
      end else begin
         if (lane16)
            exp_rd = dev_rd(v.addr);
         else if (p == 2)
            exp_rd = {dev_rd(v.addr | 24'h1) [7:0], dev_rd(v.addr)[7:0]};
         else
            exp_rd = {8'h00, dev_rd(v.addr)[7:0]};
         chk("R10 read data", 32'(rsp_rdata), 32'(exp_rd));
      end
      chk("R10 ready after done", 32'(req_ready), 32'd1);
   endtask

   initial begin
      // R1: state held in reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle("R1 in reset");
      @(posedge clk); #1;
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         run(VECS[k]);
      end

      // R1: reset mid-strobe returns every output to idle at once
      @(posedge clk); #1;
      cur_waits = 6; cur_kind = 1; cur_wr = 1;
      mem_cs16 = 1'b1;
      req_kind = 3'd1; req_write = 1'b1; req_wide = 1'b1;
      req_addr = 24'h0B0000; req_wdata = 16'h5555; req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
      repeat (A_C + 2) @(negedge clk);
      chk("R5 strobe up before reset", 32'(mem_wr), 32'd1);
      #1 rst_n = 1'b0;
      #1 check_idle("R1 mid-cycle reset");
      @(posedge clk); #1;
      rst_n = 1'b1;

      // recovery after reset: a full transaction still completes correctly
      run(VECS[1]);
      run(VECS[5]);

      summary_and_end();
   end

endmodule